// File: doc/BRIEF.md
# Quasi-Resonant Switching Cycle Sequencer

This block drives the gate enable of a single power switch in a converter running at the boundary between continuous and discontinuous conduction. Each cycle has four parts: the switch is on, then off while the transformer discharges, then a short wait for the drain voltage to reach its valley, then on again. All comparator results reach the block as clean digital flags. The block decides when each part ends, using the selected control mode, the zero-crossing flags, a programmed valley delay, and fixed minimum and maximum timers that are counted in clock cycles.

Two select bits choose the control scheme. In constant-on-time mode a ramp comparator ends the on period. In peak-current mode a current comparator ends it. The select bits also choose which over-current flag applies, the one for isolated designs or the one for non-isolated designs, and one select code holds the switch off. A separate low-frequency input replaces the loop with fixed on and off timers, for use while the converter starts up. Two single-cycle strobes mark each turn-off and each accepted zero crossing, for a supervisor elsewhere on the chip.

Top module: `qr_cycle_seq`

## Requirements
- R1: While reset is active, and in the first cycle after it is released, `gate_o`, `off_stb_o` and `zc_stb_o` are low. The sequencer starts in the off period, so with no zero crossing the first turn-on follows after the maximum off-time.
- R2: In constant-on-time modes (`mode_sel` 2'b00 or 2'b10), `ramp_hit` ends the on period once the minimum on-time has passed. If `ramp_hit` is first sampled high in on-cycle c, where c is at least TON_MIN, the gate stays high for exactly c cycles.
- R3: In peak-current mode (`mode_sel` 2'b01), `ipk_hit` ends the on period in the same way as in R2, and `ramp_hit` has no effect.
- R4: The gate stays high for at least TON_MIN and at most TON_MAX cycles. An over-current event (R5) is the only thing that can end the on period before TON_MIN.
- R5: An over-current flag ends the on period at the next clock edge in any mode. Codes 2'b00 and 2'b01 (isolated) use `oc_iso`. Code 2'b10 (non-isolated) uses `oc_niso`. The flag that is not selected is ignored.
- R6: For the first BLANK cycles of each on period, `oc_iso`, `oc_niso` and `ipk_hit` are masked. A flag held high from turn-on therefore gives an on-time of BLANK+1 cycles.
- R7: A zero crossing counts only when `zcd_above_arm` has been sampled high earlier in the same off period and `zcd_below_trig` is then sampled high. A trigger that has no arm before it is ignored.
- R8: After a counted zero crossing, the next turn-on comes 2*`dly_cnt` cycles after the off period ends. When `dly_cnt` is 0 the next turn-on comes directly.
- R9: The off period lasts at least TOFF_MIN cycles. A zero crossing counted earlier than that is held until TOFF_MIN is reached. Without a counted zero crossing, the switch turns on again after exactly TOFF_MAX low cycles.
- R10: Select code 2'b11 is reserved. While it is applied, the gate is low from the next cycle on.
- R11: With `lf_mode` high, the on-time is exactly LF_TON cycles and the off-time is exactly LF_TOFF cycles. `ramp_hit`, `ipk_hit` and the zero-crossing flags have no effect.
- R12: `off_stb_o` is high for exactly the first cycle after every turn-off. `zc_stb_o` is high for exactly one cycle, the cycle after each counted zero crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sequencer and all of its timers |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 2 | Control-scheme select; bit 0 set = first select pin grounded, bit 1 set = second |
| lf_mode | input | 1 | Selects the fixed low-frequency startup timing |
| zcd_above_arm | input | 1 | Auxiliary-winding voltage is above the arm level |
| zcd_below_trig | input | 1 | Auxiliary-winding voltage is below the trigger level |
| ramp_hit | input | 1 | PWM ramp has reached the compensation voltage |
| ipk_hit | input | 1 | Sensed current has reached the compensation-derived threshold |
| oc_iso | input | 1 | Over-current comparator flag, isolated threshold |
| oc_niso | input | 1 | Over-current comparator flag, non-isolated threshold |
| dly_cnt | input | DLY_W | Valley delay unit in clock cycles (the applied wait is twice this value) |
| gate_o | output | 1 | Gate enable for the power switch |
| off_stb_o | output | 1 | Single-cycle strobe after each turn-off |
| zc_stb_o | output | 1 | Single-cycle strobe after each counted zero crossing |

## Verification
Each flag that ends a period is sampled at one clock edge, and the gate changes at that same edge. A flag driven during on-cycle c therefore gives a pulse exactly c cycles wide, and a trigger driven during off-cycle t, when t is at least TOFF_MIN, gives a low interval of t + 2*`dly_cnt` cycles. The strobes come from registers and appear one cycle after the event that causes them. The bench drives inputs on the falling edge and counts gate-high and gate-low samples on the falling edge, so each expected width is a plain sum of the parameters. It checks `off_stb_o` in the first low sample and counts `zc_stb_o` pulses across the whole low interval.

// File: rtl/qr_seq_pkg.sv
package qr_seq_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_VLY  = 2'd2,
    ST_HALT = 2'd3
  } qr_state_t;

  // Duration in ns -> clock cycles, rounded up so a minimum is never shortened.
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // Valley wait applied after a counted zero crossing.
  function automatic int unsigned valley_cycles(input int unsigned unit_cnt);
    return 2 * unit_cnt;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/qr_mode_decode.sv
module qr_mode_decode (
  input  logic [1:0] mode_sel,
  output logic       use_cot,
  output logic       isolated,
  output logic       reserved
);
  // 00: COT isolated, 01: PCM isolated, 10: COT non-isolated, 11: reserved
  always_comb begin
    reserved = (mode_sel == 2'b11);
    use_cot  = !mode_sel[0];
    isolated = !mode_sel[1];
  end
endmodule

// File: rtl/qr_zcd_track.sv
module qr_zcd_track (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic above_arm,
  input  logic below_trig,
  output logic trig_valid
);
  logic armed;

  assign trig_valid = en && armed && below_trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          armed <= 1'b0;
    else if (!en)        armed <= 1'b0;
    else if (trig_valid) armed <= 1'b0;
    else if (above_arm)  armed <= 1'b1;
  end

  // R7
  rearm_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_valid |=> !armed);

  // R7
  arm_only_when_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !armed);
endmodule

// File: rtl/qr_cycle_seq.sv
module qr_cycle_seq
  import qr_seq_pkg::*;
#(
  parameter int unsigned CLK_MHZ     = 100,
  parameter int unsigned TON_MIN_NS  = 540,
  parameter int unsigned TON_MAX_NS  = 44000,
  parameter int unsigned TOFF_MIN_NS = 1500,
  parameter int unsigned TOFF_MAX_NS = 70000,
  parameter int unsigned LF_TON_NS   = 1500,
  parameter int unsigned LF_TOFF_NS  = 72000,
  parameter int unsigned BLANK_CYC   = 20,
  parameter int unsigned DLY_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             lf_mode,
  input  logic             zcd_above_arm,
  input  logic             zcd_below_trig,
  input  logic             ramp_hit,
  input  logic             ipk_hit,
  input  logic             oc_iso,
  input  logic             oc_niso,
  input  logic [DLY_W-1:0] dly_cnt,
  output logic             gate_o,
  output logic             off_stb_o,
  output logic             zc_stb_o
);
  localparam int unsigned TON_MIN_C  = ns_to_cyc(TON_MIN_NS, CLK_MHZ);
  localparam int unsigned TON_MAX_C  = ns_to_cyc(TON_MAX_NS, CLK_MHZ);
  localparam int unsigned TOFF_MIN_C = ns_to_cyc(TOFF_MIN_NS, CLK_MHZ);
  localparam int unsigned TOFF_MAX_C = ns_to_cyc(TOFF_MAX_NS, CLK_MHZ);
  localparam int unsigned LF_TON_C   = ns_to_cyc(LF_TON_NS, CLK_MHZ);
  localparam int unsigned LF_TOFF_C  = ns_to_cyc(LF_TOFF_NS, CLK_MHZ);
  localparam int unsigned VLY_MAX_C  = valley_cycles((1 << DLY_W) - 1);
  localparam int unsigned ON_CEIL_C  = max2(TON_MAX_C, LF_TON_C);
  localparam int unsigned OFF_CEIL_C = max2(TOFF_MAX_C, LF_TOFF_C);
  localparam int unsigned LIM_C      = max2(max2(ON_CEIL_C, OFF_CEIL_C), max2(VLY_MAX_C, BLANK_CYC));
  localparam int          CW         = $clog2(LIM_C + 1);

  localparam logic [CW-1:0] TON_MIN_M1  = CW'(TON_MIN_C - 1);
  localparam logic [CW-1:0] TON_MAX_M1  = CW'(TON_MAX_C - 1);
  localparam logic [CW-1:0] TOFF_MIN_M1 = CW'(TOFF_MIN_C - 1);
  localparam logic [CW-1:0] TOFF_MAX_M1 = CW'(TOFF_MAX_C - 1);
  localparam logic [CW-1:0] LF_TON_M1   = CW'(LF_TON_C - 1);
  localparam logic [CW-1:0] LF_TOFF_M1  = CW'(LF_TOFF_C - 1);
  localparam logic [CW-1:0] ON_CEIL_M1  = CW'(ON_CEIL_C - 1);
  localparam logic [CW-1:0] OFF_CEIL_M1 = CW'(OFF_CEIL_C - 1);
  localparam logic [CW-1:0] BLANK_LIM   = CW'(BLANK_CYC);

  qr_state_t     st, st_nx;
  logic [CW-1:0] cnt, cnt_p1, vly_len;
  logic          zc_seen;

  // Named internal events, used by the assertions below.
  logic dec_cot, dec_iso, dec_res;
  logic trig_valid;
  logic blank_done, oc_sel, oc_hit, loop_end, on_done;
  logic zc_ok, off_zc_done, off_to, vly_done;

  qr_mode_decode u_dec (
    .mode_sel (mode_sel),
    .use_cot  (dec_cot),
    .isolated (dec_iso),
    .reserved (dec_res)
  );

  qr_zcd_track u_zcd (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (st == ST_OFF),
    .above_arm  (zcd_above_arm),
    .below_trig (zcd_below_trig),
    .trig_valid (trig_valid)
  );

  assign cnt_p1  = cnt + 1'b1;
  assign vly_len = CW'({dly_cnt, 1'b0});

  always_comb begin
    blank_done  = (cnt >= BLANK_LIM);
    oc_sel      = dec_iso ? oc_iso : oc_niso;
    oc_hit      = blank_done && oc_sel;
    loop_end    = dec_cot ? ramp_hit : (blank_done && ipk_hit);
    on_done     = lf_mode ? (cnt >= LF_TON_M1)
                          : ((cnt >= TON_MAX_M1) || ((cnt >= TON_MIN_M1) && loop_end));
    zc_ok       = zc_seen || trig_valid;
    off_zc_done = !lf_mode && zc_ok && (cnt >= TOFF_MIN_M1);
    off_to      = lf_mode ? (cnt >= LF_TOFF_M1) : (cnt >= TOFF_MAX_M1);
    vly_done    = (cnt_p1 >= vly_len);
  end

  always_comb begin
    st_nx = st;
    if (dec_res) begin
      st_nx = ST_HALT;
    end else begin
      case (st)
        ST_HALT: st_nx = ST_OFF;
        ST_ON:   if (oc_hit || on_done) st_nx = ST_OFF;
        ST_OFF: begin
          if (off_zc_done)  st_nx = (dly_cnt == '0) ? ST_ON : ST_VLY;
          else if (off_to)  st_nx = ST_ON;
        end
        ST_VLY:  if (vly_done) st_nx = ST_ON;
        default: st_nx = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_OFF;
      cnt       <= '0;
      zc_seen   <= 1'b0;
      off_stb_o <= 1'b0;
      zc_stb_o  <= 1'b0;
    end else begin
      st        <= st_nx;
      cnt       <= ((st_nx != st) || (st_nx == ST_HALT)) ? '0 : cnt_p1;
      zc_seen   <= (st == ST_OFF) && (st_nx == ST_OFF) && zc_ok;
      off_stb_o <= (st == ST_ON) && (st_nx != ST_ON);
      zc_stb_o  <= trig_valid;
    end
  end

  assign gate_o = (st == ST_ON);

  // R4
  on_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ON) |-> (cnt <= ON_CEIL_M1));

  // R4
  on_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == ST_ON) && (st_nx == ST_OFF) && !oc_hit && !lf_mode) |-> (cnt >= TON_MIN_M1));

  // R9
  off_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF) |-> (cnt <= OFF_CEIL_M1));

  // R10
  reserved_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_res |=> !gate_o);

  // R12
  fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(gate_o) |-> off_stb_o);

  // R12
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off_stb_o |=> !off_stb_o);
endmodule

// File: tb/qr_cycle_seq_tb.sv
module qr_cycle_seq_tb;
  localparam int DLY_W = 8;
  // Expected limits in cycles at 200 MHz (5 ns per cycle).
  localparam int TON_MIN  = 10;
  localparam int TON_MAX  = 40;
  localparam int TOFF_MIN = 20;
  localparam int TOFF_MAX = 80;
  localparam int LF_TON   = 15;
  localparam int LF_TOFF  = 60;
  localparam int BLANK    = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic lf_mode = 1'b0, zarm = 1'b0, ztrig = 1'b0;
  logic ramp = 1'b0, ipk = 1'b0, oci = 1'b0, ocn = 1'b0;
  logic [DLY_W-1:0] dly = '0;
  logic gate_o, off_stb_o, zc_stb_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  qr_cycle_seq #(
    .CLK_MHZ(200), .TON_MIN_NS(50), .TON_MAX_NS(200), .TOFF_MIN_NS(100),
    .TOFF_MAX_NS(400), .LF_TON_NS(75), .LF_TOFF_NS(300), .BLANK_CYC(BLANK), .DLY_W(DLY_W)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lf_mode(lf_mode),
    .zcd_above_arm(zarm), .zcd_below_trig(ztrig), .ramp_hit(ramp), .ipk_hit(ipk),
    .oc_iso(oci), .oc_niso(ocn), .dly_cnt(dly),
    .gate_o(gate_o), .off_stb_o(off_stb_o), .zc_stb_o(zc_stb_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_gate(input logic v);
    int n = 0;
    while (gate_o !== v && n < 3000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 3000) chk("watchdog gate wait", 0, 1);
  endtask

  task automatic set_flag(input int which, input logic v);
    case (which)
      0: ramp = v;
      1: ipk  = v;
      2: oci  = v;
      default: ocn = v;
    endcase
  endtask

  // Gate-high width of the next full pulse; flag 'which' raised at on-sample 'at'.
  task automatic measure_on(input int which, input int at, output int w);
    wait_gate(1'b0);
    wait_gate(1'b1);
    w = 0;
    while (gate_o === 1'b1 && w < 5000) begin
      w++;
      if (w == at) set_flag(which, 1'b1);
      @(negedge clk);
    end
    set_flag(which, 1'b0);
  endtask

  // Gate-low width of the next off interval with scripted zero-crossing flags.
  task automatic measure_off(input int arm_at, input int trig_at,
                             output int w, output int zc_n, output int first_stb);
    wait_gate(1'b1);
    wait_gate(1'b0);
    w = 0; zc_n = 0; first_stb = 0;
    while (gate_o === 1'b0 && w < 5000) begin
      w++;
      if (w == 1) first_stb = int'(off_stb_o);
      if (zc_stb_o) zc_n++;
      if (w == arm_at) zarm = 1'b1;
      if (w == arm_at + 1) zarm = 1'b0;
      if (w == trig_at) ztrig = 1'b1;
      @(negedge clk);
    end
    zarm = 1'b0;
    ztrig = 1'b0;
  endtask

  task automatic t_reset;
    int w = 0;
    chk("R1 gate in reset", int'(gate_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 off strobe after reset", int'(off_stb_o), 0);
    chk("R1 zc strobe after reset", int'(zc_stb_o), 0);
    while (gate_o === 1'b0 && w < 5000) begin
      w++;
      @(negedge clk);
    end
    chk("R1 R9 first turn-on after max off", w, TOFF_MAX);
  endtask

  task automatic t_cot;
    int w;
    mode_sel = 2'b00;
    measure_on(0, 25, w); chk("R2 ramp ends on-time", w, 25);
    measure_on(0, 1, w);  chk("R4 min on-time clamp", w, TON_MIN);
    measure_on(0, 0, w);  chk("R4 max on-time clamp", w, TON_MAX);
    measure_on(1, 12, w); chk("R2 ipk ignored in COT", w, TON_MAX);
  endtask

  task automatic t_pcm;
    int w;
    mode_sel = 2'b01;
    measure_on(1, 15, w); chk("R3 ipk ends on-time", w, 15);
    measure_on(0, 15, w); chk("R3 ramp ignored in PCM", w, TON_MAX);
    measure_on(1, 1, w);  chk("R3 R4 ipk held gives min", w, TON_MIN);
  endtask

  task automatic t_oc;
    int w;
    mode_sel = 2'b00;
    measure_on(2, 6, w);  chk("R5 iso OC immediate", w, 6);
    measure_on(3, 6, w);  chk("R5 niso OC ignored when isolated", w, TON_MAX);
    measure_on(2, 1, w);  chk("R6 blanking on OC", w, BLANK + 1);
    mode_sel = 2'b10;
    measure_on(3, 6, w);  chk("R5 niso OC immediate", w, 6);
    measure_on(2, 6, w);  chk("R5 iso OC ignored when non-isolated", w, TON_MAX);
    mode_sel = 2'b01;
    measure_on(2, 7, w);  chk("R5 iso OC in PCM", w, 7);
  endtask

  task automatic t_zcd;
    int w, zc, fs;
    mode_sel = 2'b00;
    ramp = 1'b1;
    dly = 8'd4;
    measure_off(5, 30, w, zc, fs);
    chk("R7 R8 armed trigger plus valley", w, 30 + 2 * 4);
    chk("R12 one zc strobe", zc, 1);
    chk("R12 off strobe first low cycle", fs, 1);
    measure_off(3, 8, w, zc, fs);
    chk("R9 early trigger held to min off", w, TOFF_MIN + 2 * 4);
    chk("R12 zc strobe early trigger", zc, 1);
    measure_off(0, 30, w, zc, fs);
    chk("R7 unarmed trigger ignored", w, TOFF_MAX);
    chk("R7 no zc strobe when unarmed", zc, 0);
    dly = 8'd0;
    measure_off(5, 30, w, zc, fs);
    chk("R8 zero valley delay", w, 30);
    dly = 8'd7;
    measure_off(5, 25, w, zc, fs);
    chk("R8 valley delay 7", w, 25 + 14);
    ramp = 1'b0;
    dly = '0;
  endtask

  task automatic t_lf;
    int w, zc, fs;
    mode_sel = 2'b00;
    lf_mode = 1'b1;
    measure_on(0, 1, w); chk("R11 fixed on-time ramp held", w, LF_TON);
    measure_on(0, 0, w); chk("R11 fixed on-time ramp low", w, LF_TON);
    measure_off(5, 30, w, zc, fs);
    chk("R11 fixed off-time ignores zcd", w, LF_TOFF);
    lf_mode = 1'b0;
  endtask

  task automatic t_reserved;
    int hi = 0;
    int w;
    wait_gate(1'b1);
    @(negedge clk);
    mode_sel = 2'b11;
    @(negedge clk);
    chk("R10 reserved turns gate off", int'(gate_o), 0);
    chk("R12 off strobe on forced off", int'(off_stb_o), 1);
    for (int i = 0; i < 200; i++) begin
      if (gate_o) hi++;
      @(negedge clk);
    end
    chk("R10 reserved keeps switch off", hi, 0);
    mode_sel = 2'b00;
    measure_on(0, 20, w); chk("R2 recovery after reserved", w, 20);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_cot();
    t_pcm();
    t_oc();
    t_zcd();
    t_lf();
    t_reserved();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule